// File: doc/BRIEF.md
# Trellis Recursion SIMD Unit

This unit computes one max-log-MAP recursion step, forward or backward, for a convolutional trellis of up to eight states with up to four branches per state. It holds an array of processing nodes laid out as a matrix. The column index is the destination state and the row index is the decision, or branch. Each node therefore stands for one trellis transition. Each node has a small route register that names the source state and the branch-metric index it reads. An accumulator register holds the node's result.

A sequencer drives the unit through a command port, one command per cycle. A step is built from several commands:

- An ADD command fills every accumulator at once. In metric mode a node adds a source-state metric and a branch metric. In extrinsic mode it also adds the backward metric of its own column.
- Compare-select commands then reduce the matrix by one level per command. A reduction runs either across decisions, which yields new state metrics in row 0, or across states, which yields per-decision maxima in column 0. Reducing four branches therefore takes two commands, and reducing eight states takes three.
- A normalize command re-bases the state metrics on state 0.
- A route-write command loads one node's route register.

All arithmetic is 16-bit two's complement with saturation.

Top module: `trel_simd`

## Requirements
- R1: A synchronous active-low reset clears every accumulator to 0 and every route register to 0. The clear is visible after the first rising edge with `rst_n` low.
- R2: Command code 1 is metric ADD. On the next edge every node (d,s) loads sat(alpha[src] + gamma[br]). `src` is route bits [4:2] and `br` is route bits [1:0].
- R3: Command code 2 is extrinsic ADD. On the next edge every node (d,s) loads sat(alpha[src] + gamma[br] + beta[s]), saturated once on the full sum.
- R4: Command code 3 is a decision-direction compare-select with stride k = 2^lvl. On the next edge node (d,s) takes max(acc(d,s), acc(d+k,s)) when d is a multiple of 2k and d+k < 4. All other nodes keep their values, so a level with no valid pair changes nothing.
- R5: Command code 4 is a state-direction compare-select with stride k = 2^lvl. On the next edge node (d,s) takes max(acc(d,s), acc(d,s+k)) when s is a multiple of 2k and s+k < 8. All other nodes keep their values.
- R6: Command code 5 is normalize. On the next edge each row-0 node (0,s) loads sat(acc(0,s) - acc(0,0)), using the values from before the edge. Rows 1 to 3 keep their values, so state 0 reads 0 afterwards.
- R7: Command code 6 writes `cfg_rt` into the route register of node `cfg_node`. The node index is d*8+s. Route bits [4:2] hold the source state and bits [1:0] hold the branch-metric index. No accumulator changes.
- R8: Every sum and difference saturates to the range -32768 to +32767 and never wraps.
- R9: With `cmd_valid` low, or with command code 0 or 7, no accumulator and no route register changes.
- R10: `radd_o` carries node d*8+s at bits [(d*8+s)*16 +: 16]. `metric_o` carries row 0, with state s at [s*16 +: 16]. `decmax_o` carries column 0, with decision d at [d*16 +: 16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_lvl | input | 2 | Compare-select level, stride 2^lvl |
| cfg_node | input | 5 | Node index for a route write |
| cfg_rt | input | 5 | Route value: source state and branch index |
| alpha_i | input | 128 | Source-state metrics, 8 x 16 |
| gamma_i | input | 64 | Branch metrics, 4 x 16 |
| beta_i | input | 128 | Backward metrics by column, 8 x 16 |
| radd_o | output | 512 | All accumulators, 32 x 16 |
| metric_o | output | 128 | Row 0: new state metrics |
| decmax_o | output | 64 | Column 0: per-decision maxima |

## Verification
The bench builds the unit with its default parameters: 16-bit metrics, 8 states and 4 decisions. This is the full eight-state double-binary case, so every stride level in both reduction directions is reached, together with the levels that have no valid pair. A random eight-state trellis with random branch-metric routing is loaded through route writes. Several forward steps are then run, each fed from the previous step's metrics. An extrinsic pass is checked against a direct max-over-states computation. Accumulator values are forced to both saturation limits, and normalize is applied across a full-scale spread.

// File: rtl/trel_pkg.sv
// Shared command encoding for the trellis recursion unit.
// Assumes a 3-bit command code; code 7 is reserved and has no effect.
package trel_pkg;
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ADDM = 3'd1,
        OP_ADDX = 3'd2,
        OP_MAXD = 3'd3,
        OP_MAXS = 3'd4,
        OP_NORM = 3'd5,
        OP_CFG  = 3'd6,
        OP_RSV  = 3'd7
    } op_e;
endpackage

// File: rtl/trel_node.sv
// One processing node of the recursion matrix (row D_IDX, column S_IDX).
// Holds a route register (source state, branch index) and a saturating
// accumulator. The compare partner and its enable come from the parent,
// which knows the matrix geometry; the node only performs the select.
module trel_node
    import trel_pkg::*;
#(
    parameter int W     = 16,
    parameter int NS    = 8,
    parameter int ND    = 4,
    parameter int D_IDX = 0,
    parameter int S_IDX = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  op_e                      cmd_op,
    input  logic [$clog2(NS*ND)-1:0] cfg_node,
    input  logic [$clog2(NS)+$clog2(ND)-1:0] cfg_rt,
    input  logic [NS-1:0][W-1:0]     alpha_i,
    input  logic [ND-1:0][W-1:0]     gamma_i,
    input  logic signed [W-1:0]      beta_col,
    input  logic                     cmp_en,
    input  logic signed [W-1:0]      cmp_b,
    input  logic signed [W-1:0]      norm_ref,
    output logic signed [W-1:0]      radd_q
);
    localparam int SW = $clog2(NS);
    localparam int BW = $clog2(ND);
    localparam int CW = SW + BW;
    localparam int NW = $clog2(NS*ND);
    localparam logic [NW-1:0] MY_ID = NW'(D_IDX*NS + S_IDX);
    localparam logic signed [W+1:0] MAXV = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [W+1:0] MINV = {3'b111, {(W-1){1'b0}}};

    logic [CW-1:0]         rt_q;
    logic [SW-1:0]         src;
    logic [BW-1:0]         br;
    logic signed [W-1:0]   a_v, g_v;
    logic signed [W+1:0]   sum_m, sum_x, dif;
    logic signed [W-1:0]   nxt;

    // Clamp a widened value into the W-bit signed range.
    function automatic logic signed [W-1:0] sat(input logic signed [W+1:0] v);
        if (v > MAXV)      return MAXV[W-1:0];
        else if (v < MINV) return MINV[W-1:0];
        else               return v[W-1:0];
    endfunction

    // Route register: loaded only by a route write addressed to this node.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rt_q <= '0;
        else if (cmd_valid && cmd_op == OP_CFG && cfg_node == MY_ID)
            rt_q <= cfg_rt;
    end

    assign src = rt_q[CW-1:BW];
    assign br  = rt_q[BW-1:0];

    // Operand selection and widened sums.
    always_comb begin
        a_v   = $signed(alpha_i[src]);
        g_v   = $signed(gamma_i[br]);
        sum_m = (W+2)'(a_v) + (W+2)'(g_v);
        sum_x = sum_m + (W+2)'(beta_col);
        dif   = (W+2)'(radd_q) - (W+2)'(norm_ref);
    end

    // Next accumulator value per command.
    always_comb begin
        nxt = radd_q;
        if (cmd_valid) begin
            case (cmd_op)
                OP_ADDM: nxt = sat(sum_m);
                OP_ADDX: nxt = sat(sum_x);
                OP_MAXD,
                OP_MAXS: if (cmp_en && cmp_b > radd_q) nxt = cmp_b;
                OP_NORM: if (D_IDX == 0) nxt = sat(dif);
                default: nxt = radd_q;
            endcase
        end
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) radd_q <= '0;
        else        radd_q <= nxt;
    end

    // R4/R5: a selected compare never leaves a value below either input.
    a_r4_max_dominates: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_MAXD || cmd_op == OP_MAXS) && cmp_en)
        |=> (radd_q >= $past(cmp_b) && radd_q >= $past(radd_q)));
endmodule

// File: rtl/trel_simd.sv
// Trellis recursion SIMD unit: NS x ND matrix of nodes, column = state,
// row = decision. Decodes the command and routes compare partners for one
// reduction level per command. Assumes NS and ND are powers of two.
module trel_simd
    import trel_pkg::*;
#(
    parameter int W  = 16,
    parameter int NS = 8,
    parameter int ND = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cmd_valid,
    input  logic [2:0]                         cmd_op,
    input  logic [$clog2($clog2(NS)+1)-1:0]    cmd_lvl,
    input  logic [$clog2(NS*ND)-1:0]           cfg_node,
    input  logic [$clog2(NS)+$clog2(ND)-1:0]   cfg_rt,
    input  logic [NS*W-1:0]                    alpha_i,
    input  logic [ND*W-1:0]                    gamma_i,
    input  logic [NS*W-1:0]                    beta_i,
    output logic [NS*ND*W-1:0]                 radd_o,
    output logic [NS*W-1:0]                    metric_o,
    output logic [ND*W-1:0]                    decmax_o
);
    localparam int NN = NS * ND;

    op_e                   op;
    int                    lvl_i;
    logic [NS-1:0][W-1:0]  alpha_v;
    logic [ND-1:0][W-1:0]  gamma_v;
    logic [NS-1:0][W-1:0]  beta_v;
    logic signed [W-1:0]   radd [NN];

    assign op      = op_e'(cmd_op);
    assign lvl_i   = int'(cmd_lvl);
    assign alpha_v = alpha_i;
    assign gamma_v = gamma_i;
    assign beta_v  = beta_i;

    for (genvar d = 0; d < ND; d++) begin : g_row
        for (genvar s = 0; s < NS; s++) begin : g_col
            localparam int N = d*NS + s;
            logic                cmp_en;
            logic signed [W-1:0] cmp_b;

            // Pick this node's partner for the current level and direction.
            always_comb begin
                int k;
                k      = 1 << lvl_i;
                cmp_en = 1'b0;
                cmp_b  = radd[N];
                if (op == OP_MAXD && (d % (2*k)) == 0 && d + k < ND) begin
                    cmp_en = 1'b1;
                    cmp_b  = radd[(d+k)*NS + s];
                end else if (op == OP_MAXS && (s % (2*k)) == 0 && s + k < NS) begin
                    cmp_en = 1'b1;
                    cmp_b  = radd[d*NS + s + k];
                end
            end

            trel_node #(.W(W), .NS(NS), .ND(ND), .D_IDX(d), .S_IDX(s)) u_node (
                .clk      (clk),
                .rst_n    (rst_n),
                .cmd_valid(cmd_valid),
                .cmd_op   (op),
                .cfg_node (cfg_node),
                .cfg_rt   (cfg_rt),
                .alpha_i  (alpha_v),
                .gamma_i  (gamma_v),
                .beta_col ($signed(beta_v[s])),
                .cmp_en   (cmp_en),
                .cmp_b    (cmp_b),
                .norm_ref (radd[0]),
                .radd_q   (radd[N])
            );

            assign radd_o[N*W +: W] = radd[N];
            if (d == 0) begin : g_met
                assign metric_o[s*W +: W] = radd[N];
            end
            if (s == 0) begin : g_dec
                assign decmax_o[d*W +: W] = radd[N];
            end
        end
    end

    // R1: reset clears the whole accumulator array.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (radd_o == '0));

    // R9: an idle strobe leaves every accumulator untouched.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(radd_o));

    // R7: a route write does not disturb accumulators.
    a_r7_cfg_no_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_CFG) |=> $stable(radd_o));

    // R6: after normalize the reference state reads zero.
    a_r6_norm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_NORM) |=> (metric_o[W-1:0] == '0));
endmodule

// File: tb/trel_simd_tb.sv
// Bench: behavioural per-command model of the accumulator matrix, compared
// on every command, plus direct max-log-MAP recursion checks.
module trel_simd_tb;
    localparam int W = 16, NS = 8, ND = 4, NN = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, cmd_valid;
    logic [2:0]        cmd_op;
    logic [1:0]        cmd_lvl;
    logic [4:0]        cfg_node, cfg_rt;
    logic [NS*W-1:0]   alpha_i, beta_i;
    logic [ND*W-1:0]   gamma_i;
    logic [NN*W-1:0]   radd_o;
    logic [NS*W-1:0]   metric_o;
    logic [ND*W-1:0]   decmax_o;

    trel_simd u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_lvl(cmd_lvl), .cfg_node(cfg_node), .cfg_rt(cfg_rt),
        .alpha_i(alpha_i), .gamma_i(gamma_i), .beta_i(beta_i),
        .radd_o(radd_o), .metric_o(metric_o), .decmax_o(decmax_o)
    );

    int checks = 0, errors = 0;
    int m_acc [NN];
    int m_src [NN];
    int m_br  [NN];
    int a_v [NS];
    int g_v [ND];
    int b_v [NS];

    function automatic int sat(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic pack_inputs();
        for (int s = 0; s < NS; s++) begin
            alpha_i[s*W +: W] = a_v[s][W-1:0];
            beta_i[s*W +: W]  = b_v[s][W-1:0];
        end
        for (int d = 0; d < ND; d++) gamma_i[d*W +: W] = g_v[d][W-1:0];
    endtask

    // Compare every accumulator against the model: one check.
    task automatic cmp_all(input string tag);
        bit bad = 0;
        checks++;
        for (int n = 0; n < NN; n++) begin
            int got;
            got = $signed(radd_o[n*W +: W]);
            if (got != m_acc[n] && !bad) begin
                $display("FAIL %s node %0d actual %0d expected %0d", tag, n, got, m_acc[n]);
                bad = 1;
            end
        end
        if (bad) errors++;
    endtask

    // Issue one command, advance the model, compare after the edge.
    task automatic step(input int op, input int lvl, input int node, input int rt,
                        input bit valid, input string tag);
        int nx [NN];
        int k;
        @(negedge clk);
        cmd_valid = valid; cmd_op = op[2:0]; cmd_lvl = lvl[1:0];
        cfg_node = node[4:0]; cfg_rt = rt[4:0];
        pack_inputs();
        nx = m_acc;
        k = 1 << lvl;
        if (valid) begin
            case (op)
                1: for (int n = 0; n < NN; n++) nx[n] = sat(a_v[m_src[n]] + g_v[m_br[n]]);
                2: for (int n = 0; n < NN; n++) nx[n] = sat(a_v[m_src[n]] + g_v[m_br[n]] + b_v[n % NS]);
                3: for (int d = 0; d < ND; d++) for (int s = 0; s < NS; s++)
                       if (d % (2*k) == 0 && d + k < ND && m_acc[(d+k)*NS+s] > m_acc[d*NS+s])
                           nx[d*NS+s] = m_acc[(d+k)*NS+s];
                4: for (int d = 0; d < ND; d++) for (int s = 0; s < NS; s++)
                       if (s % (2*k) == 0 && s + k < NS && m_acc[d*NS+s+k] > m_acc[d*NS+s])
                           nx[d*NS+s] = m_acc[d*NS+s+k];
                5: for (int s = 0; s < NS; s++) nx[s] = sat(m_acc[s] - m_acc[0]);
                6: begin m_src[node] = rt / 4; m_br[node] = rt % 4; end
                default: ;
            endcase
        end
        @(posedge clk); #1;
        m_acc = nx;
        cmd_valid = 1'b0;
        cmp_all(tag);
    endtask

    task automatic chk(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, got, exp);
        end
    endtask

    int pred [ND][NS];
    int brs  [ND][NS];

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_lvl = '0;
        cfg_node = '0; cfg_rt = '0;
        for (int s = 0; s < NS; s++) begin a_v[s] = 0; b_v[s] = 0; end
        for (int d = 0; d < ND; d++) g_v[d] = 0;
        pack_inputs();
        for (int n = 0; n < NN; n++) begin m_acc[n] = 0; m_src[n] = 0; m_br[n] = 0; end
        repeat (3) @(posedge clk);
        #1 cmp_all("R1 reset");
        @(negedge clk) rst_n = 1'b1;

        // Random 8-state trellis: each decision row is a state permutation.
        for (int d = 0; d < ND; d++) begin
            int mul, off;
            mul = 2*$urandom_range(0, 3) + 1;
            off = $urandom_range(0, 7);
            for (int s = 0; s < NS; s++) begin
                pred[d][s] = (s*mul + off) % NS;
                brs[d][s]  = $urandom_range(0, 3);
                step(6, 0, d*NS+s, pred[d][s]*4 + brs[d][s], 1'b1, "R7 route write");
            end
        end

        // Forward recursion steps, each fed from the previous metrics.
        for (int s = 0; s < NS; s++) a_v[s] = $urandom_range(0, 4000) - 2000;
        for (int it = 0; it < 4; it++) begin
            int ex [NS];
            for (int d = 0; d < ND; d++) g_v[d] = $urandom_range(0, 2000) - 1000;
            for (int s = 0; s < NS; s++) begin
                ex[s] = -40000;
                for (int d = 0; d < ND; d++)
                    if (sat(a_v[pred[d][s]] + g_v[brs[d][s]]) > ex[s])
                        ex[s] = sat(a_v[pred[d][s]] + g_v[brs[d][s]]);
            end
            for (int s = NS-1; s >= 0; s--) ex[s] = sat(ex[s] - ex[0]);
            step(1, 0, 0, 0, 1'b1, "R2 metric add");
            step(3, 0, 0, 0, 1'b1, "R4 decision max l0");
            step(3, 1, 0, 0, 1'b1, "R4 decision max l1");
            step(5, 0, 0, 0, 1'b1, "R6 normalize");
            for (int s = 0; s < NS; s++) begin
                chk($signed(metric_o[s*W +: W]), ex[s], "R6 R10 recursion metric");
                a_v[s] = $signed(metric_o[s*W +: W]);
            end
        end

        // Extrinsic pass: max over states per decision in column 0.
        begin
            int ex [ND];
            for (int s = 0; s < NS; s++) b_v[s] = $urandom_range(0, 4000) - 2000;
            for (int d = 0; d < ND; d++) begin
                ex[d] = -40000;
                for (int s = 0; s < NS; s++)
                    if (sat(a_v[pred[d][s]] + g_v[brs[d][s]] + b_v[s]) > ex[d])
                        ex[d] = sat(a_v[pred[d][s]] + g_v[brs[d][s]] + b_v[s]);
            end
            step(2, 0, 0, 0, 1'b1, "R3 extrinsic add");
            step(4, 0, 0, 0, 1'b1, "R5 state max l0");
            step(4, 1, 0, 0, 1'b1, "R5 state max l1");
            step(4, 2, 0, 0, 1'b1, "R5 state max l2");
            for (int d = 0; d < ND; d++)
                chk($signed(decmax_o[d*W +: W]), ex[d], "R5 R10 decision maximum");
        end

        // Levels with no valid pair, and ignored commands.
        step(3, 2, 0, 0, 1'b1, "R4 empty level");
        step(4, 3, 0, 0, 1'b1, "R5 empty level");
        step(1, 0, 0, 0, 1'b0, "R9 strobe low");
        step(7, 0, 0, 0, 1'b1, "R9 reserved code");
        step(0, 0, 0, 0, 1'b1, "R9 nop");
        step(6, 0, 5, 31, 1'b0, "R9 route write without strobe");
        step(1, 0, 0, 0, 1'b1, "R9 route unchanged");

        // Saturation at both limits, then normalize across full scale.
        for (int s = 0; s < NS; s++) step(6, 0, s, s*4 + (s == 2 ? 1 : 0), 1'b1, "R7 row0 reroute");
        a_v[0] = -30000; a_v[1] = 30000; a_v[2] = 31000;
        g_v[0] = -3000;  g_v[1] = 2000;
        step(1, 0, 0, 0, 1'b1, "R8 add saturation");
        chk($signed(metric_o[0 +: W]), -32768, "R8 low clamp");
        chk($signed(metric_o[2*W +: W]), 32767, "R8 high clamp");
        step(5, 0, 0, 0, 1'b1, "R8 normalize saturation");
        chk($signed(metric_o[W +: W]), 32767, "R8 normalize clamp");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule